// File: doc/BRIEF.md
# USB OUT endpoint transfer controller

This block follows one device-side USB OUT endpoint through a software-programmed transfer. Software writes a byte budget, a packet count, the endpoint kind (isochronous or not), a max packet size and a frame-parity selector, together with an enable bit and a clear-NAK bit. From then on, each packet event from the packet-level receiver is accepted and pushed into the receive FIFO, or it is refused. Acceptance lowers the remaining packet count and the remaining byte budget. A refused packet gets a NAK handshake, or is silently dropped on an isochronous endpoint.

The block keeps a mirror of the FIFO occupancy and the data PID of each stored packet. A level interrupt stays high while any entry waits. When software pops the entry that closes the transfer, a transfer-done interrupt rises and the endpoint disables itself. After that, software can read the remaining byte budget to work out how much data arrived. An isochronous endpoint only takes packets in frames whose parity matches its selector. It copies the PID of every packet software pops into a readable field. It can only be armed between an end-of-periodic-frame pulse and the following start-of-frame pulse.

Top module: `out_ep_xfer_ctrl`

## Requirements
- R1: After reset the endpoint is disabled, the FIFO level, remaining size and remaining packet count are 0, both interrupts are low and the last-PID field is DATA0 (2'b00).
- R2: A configuration write arms the endpoint only when it carries both enable and clear-NAK and the endpoint is currently disabled. It then loads size and packet count and clears the done interrupt. Any other write leaves every output unchanged.
- R3: An accepted packet asserts `rx_push` in the cycle of `rx_valid`. In the next cycle it has decremented the packet count by 1 and the remaining size by the packet's byte count, with the size floored at 0.
- R4: A packet is refused (`rx_nak` high, `rx_push` low, counters unchanged) when the endpoint is disabled, when the transfer is already closed or has no packets left, or when the FIFO already holds DEPTH entries.
- R5: `irq_rx_level` is high exactly while the FIFO level is non-zero. Each pop lowers the level by one, and a pop with an empty FIFO is ignored.
- R6: A non-isochronous transfer closes on the packet that brings the count to 0 or on a packet shorter than the max packet size. Popping the last FIFO entry of a closed transfer raises `irq_xfer_done` and clears `ep_enabled` in the following cycle. The interrupt then stays high until `done_ack` or the next arming write.
- R7: An isochronous endpoint accepts a packet only while `frame_odd` equals the parity selector latched when it was armed. Otherwise the packet is refused.
- R8: On an isochronous endpoint a packet shorter than the max packet size does not close the transfer. Only the packet count reaching 0 closes it.
- R9: Each pop on an isochronous endpoint copies the PID of the popped entry, in arrival order, into `last_pid`. The encoding is DATA0=2'b00, DATA1=2'b10, DATA2=2'b01, MDATA=2'b11. Pops on a non-isochronous endpoint leave `last_pid` unchanged.
- R10: An arming write for an isochronous endpoint is ignored unless the arming window is open. A `frame_eop` pulse opens the window, a `frame_sof` pulse closes it, and it is open out of reset. Non-isochronous arming ignores the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Enable bit of the write |
| cfg_clear_nak | input | 1 | Clear-NAK bit of the write |
| cfg_iso | input | 1 | 1 = isochronous endpoint |
| cfg_odd_frame | input | 1 | Frame parity in which an isochronous endpoint receives |
| cfg_size | input | SIZE_W | Transfer size in bytes |
| cfg_pkts | input | PKT_W | Packet count |
| cfg_mps | input | BYTE_W | Max packet size in bytes |
| frame_odd | input | 1 | Bit 0 of the current frame number |
| frame_sof | input | 1 | Start-of-frame pulse |
| frame_eop | input | 1 | End-of-periodic-frame pulse |
| rx_valid | input | 1 | Packet-received event from the receiver |
| rx_bytes | input | BYTE_W | Byte count of the packet |
| rx_pid | input | 2 | Data PID of the packet |
| rx_push | output | 1 | Packet accepted and written to the FIFO |
| rx_nak | output | 1 | Packet refused (NAK, or drop when isochronous) |
| fifo_pop | input | 1 | Software pops one FIFO entry |
| done_ack | input | 1 | Clears the transfer-done interrupt |
| irq_rx_level | output | 1 | FIFO non-empty interrupt |
| irq_xfer_done | output | 1 | Transfer-done interrupt |
| ep_enabled | output | 1 | Endpoint enable bit |
| rem_size | output | SIZE_W | Remaining byte budget |
| rem_pkts | output | PKT_W | Remaining packet count |
| fifo_level | output | LVL_W | Entries held in the receive FIFO |
| last_pid | output | 2 | PID of the last isochronous entry popped |

## Verification
The bench sweeps non-isochronous transfers of every packet count from one to five, with the closing short packet at every possible position. A design that ignored short packets would keep accepting data and never complete. A design that closed on the wrong packet would report a wrong remaining size. The bench fills the FIFO to its depth and sends one more packet, pops an empty FIFO, and overruns the byte budget. These cases expose an overflowing level counter, a refusal that still moves the counters, and a size that wraps instead of stopping at 0. On the isochronous side the bench sends packets in frames of the wrong parity and short packets in the middle of a transfer. It uses all four PID codes in arrival order and arms outside the frame window. Each case catches a design that takes wrong-frame data, closes early, reorders or skips PIDs, or arms when it should not.

// File: rtl/oep_pkg.sv
package oep_pkg;

  // Two-bit data PID code as stored per FIFO entry.
  typedef enum logic [1:0] {
    PID_DATA0 = 2'b00,
    PID_DATA2 = 2'b01,
    PID_DATA1 = 2'b10,
    PID_MDATA = 2'b11
  } pid_e;

endpackage

// File: rtl/oep_accept_gate.sv
// Combinational accept / refuse decision for one incoming OUT packet.
module oep_accept_gate #(
  parameter int PKT_W  = 4,
  parameter int BYTE_W = 7,
  parameter int DEPTH  = 4,
  parameter int LVL_W  = 3
) (
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_bytes,
  input  logic              ep_en,
  input  logic              closed,
  input  logic [PKT_W-1:0]  rem_pkts,
  input  logic [LVL_W-1:0]  level,
  input  logic              iso,
  input  logic              odd_sel,
  input  logic              frame_odd,
  input  logic [BYTE_W-1:0] mps,
  output logic              accept,
  output logic              reject,
  output logic              last_pkt
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic armed;
  logic room;
  logic parity_ok;
  logic short_pkt;

  always_comb begin
    armed     = ep_en && !closed && (rem_pkts != '0);
    room      = (level < FULL_LVL);
    parity_ok = !iso || (frame_odd == odd_sel);
    short_pkt = (rx_bytes < mps);
    accept    = rx_valid && armed && room && parity_ok;
    reject    = rx_valid && !accept;
    last_pkt  = (rem_pkts == PKT_W'(1)) || (!iso && short_pkt);
  end

endmodule

// File: rtl/oep_xfer_count.sv
// Remaining byte budget and packet count of the running transfer.
module oep_xfer_count #(
  parameter int SIZE_W = 10,
  parameter int PKT_W  = 4,
  parameter int BYTE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIZE_W-1:0] load_size,
  input  logic [PKT_W-1:0]  load_pkts,
  input  logic              take,
  input  logic [BYTE_W-1:0] take_bytes,
  output logic [SIZE_W-1:0] rem_size,
  output logic [PKT_W-1:0]  rem_pkts
);

  logic [SIZE_W-1:0] size_q, size_d, take_ext;
  logic [PKT_W-1:0]  pkts_q, pkts_d;
  logic              upd;

  always_comb begin
    take_ext = SIZE_W'(take_bytes);
    upd      = load || take;
    size_d   = size_q;
    pkts_d   = pkts_q;
    if (load) begin
      size_d = load_size;
      pkts_d = load_pkts;
    end else if (take) begin
      size_d = (take_ext > size_q) ? '0 : (size_q - take_ext);
      pkts_d = pkts_q - PKT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      pkts_q <= '0;
    end else if (upd) begin
      size_q <= size_d;
      pkts_q <= pkts_d;
    end
  end

  assign rem_size = size_q;
  assign rem_pkts = pkts_q;

endmodule

// File: rtl/oep_pid_queue.sv
// Occupancy mirror of the receive FIFO holding each entry's data PID.
module oep_pid_queue
  import oep_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [1:0]       push_pid,
  input  logic             pop,
  output logic             pop_taken,
  output logic [LVL_W-1:0] level,
  output logic [1:0]       head_pid
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  pid_e             slot [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : (p + PTR_W'(1));
  endfunction

  always_comb begin
    pop_taken = pop && (lvl_q != '0);
    wr_d      = push      ? bump(wr_q) : wr_q;
    rd_d      = pop_taken ? bump(rd_q) : rd_q;
    lvl_d     = lvl_q;
    case ({push, pop_taken})
      2'b10:   lvl_d = lvl_q + LVL_W'(1);
      2'b01:   lvl_d = lvl_q - LVL_W'(1);
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    pid_e cell_q;
    logic cell_we;
    assign cell_we = push && (wr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= PID_DATA0;
      end else if (cell_we) begin
        cell_q <= pid_e'(push_pid);
      end
    end
    assign slot[g] = cell_q;
  end

  assign level    = lvl_q;
  assign head_pid = slot[rd_q];

endmodule

// File: rtl/out_ep_xfer_ctrl.sv
// One USB OUT endpoint: arming, packet accept/refuse, FIFO mirror, completion.
module out_ep_xfer_ctrl #(
  parameter  int SIZE_W = 10,
  parameter  int PKT_W  = 4,
  parameter  int BYTE_W = 7,
  parameter  int DEPTH  = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_enable,
  input  logic              cfg_clear_nak,
  input  logic              cfg_iso,
  input  logic              cfg_odd_frame,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [PKT_W-1:0]  cfg_pkts,
  input  logic [BYTE_W-1:0] cfg_mps,
  input  logic              frame_odd,
  input  logic              frame_sof,
  input  logic              frame_eop,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_bytes,
  input  logic [1:0]        rx_pid,
  output logic              rx_push,
  output logic              rx_nak,
  input  logic              fifo_pop,
  input  logic              done_ack,
  output logic              irq_rx_level,
  output logic              irq_xfer_done,
  output logic              ep_enabled,
  output logic [SIZE_W-1:0] rem_size,
  output logic [PKT_W-1:0]  rem_pkts,
  output logic [LVL_W-1:0]  fifo_level,
  output logic [1:0]        last_pid
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // Control state.
  logic              en_q, en_d;
  logic              closed_q, closed_d;
  logic              done_q, done_d;
  logic              win_q, win_d;
  logic [1:0]        pid_q, pid_d;
  logic              iso_q, odd_q;
  logic [BYTE_W-1:0] mps_q;

  logic              start;
  logic              accept, reject, last_pkt;
  logic              pop_taken;
  logic [1:0]        head_pid;
  logic [LVL_W-1:0]  level;
  logic [PKT_W-1:0]  pkts_left;
  logic [SIZE_W-1:0] size_left;
  logic              final_pop;

  oep_accept_gate #(
    .PKT_W (PKT_W),
    .BYTE_W(BYTE_W),
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
  ) u_gate (
    .rx_valid (rx_valid),
    .rx_bytes (rx_bytes),
    .ep_en    (en_q),
    .closed   (closed_q),
    .rem_pkts (pkts_left),
    .level    (level),
    .iso      (iso_q),
    .odd_sel  (odd_q),
    .frame_odd(frame_odd),
    .mps      (mps_q),
    .accept   (accept),
    .reject   (reject),
    .last_pkt (last_pkt)
  );

  oep_xfer_count #(
    .SIZE_W(SIZE_W),
    .PKT_W (PKT_W),
    .BYTE_W(BYTE_W)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (start),
    .load_size (cfg_size),
    .load_pkts (cfg_pkts),
    .take      (accept),
    .take_bytes(rx_bytes),
    .rem_size  (size_left),
    .rem_pkts  (pkts_left)
  );

  oep_pid_queue #(
    .DEPTH(DEPTH),
    .LVL_W(LVL_W)
  ) u_queue (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (accept),
    .push_pid (rx_pid),
    .pop      (fifo_pop),
    .pop_taken(pop_taken),
    .level    (level),
    .head_pid (head_pid)
  );

  // Next-state logic.
  always_comb begin
    start     = cfg_wr && cfg_enable && cfg_clear_nak && !en_q
                && (!cfg_iso || win_q);
    final_pop = pop_taken && closed_q && (level == LVL_W'(1));

    en_d     = en_q;
    closed_d = closed_q;
    done_d   = done_q;
    pid_d    = pid_q;

    if (start) begin
      en_d     = 1'b1;
      closed_d = (cfg_pkts == '0);
      done_d   = 1'b0;
    end else begin
      if (accept && last_pkt) closed_d = 1'b1;
      if (done_ack)           done_d   = 1'b0;
      if (final_pop) begin
        done_d = 1'b1;
        en_d   = 1'b0;
      end
      if (pop_taken && iso_q) pid_d = head_pid;
    end

    if (frame_eop)      win_d = 1'b1;
    else if (frame_sof) win_d = 1'b0;
    else                win_d = win_q;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q     <= 1'b0;
      closed_q <= 1'b0;
      done_q   <= 1'b0;
      win_q    <= 1'b1;
      pid_q    <= 2'b00;
    end else begin
      en_q     <= en_d;
      closed_q <= closed_d;
      done_q   <= done_d;
      win_q    <= win_d;
      pid_q    <= pid_d;
    end
  end

  // Endpoint characteristics, captured only by an arming write.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      iso_q <= 1'b0;
      odd_q <= 1'b0;
      mps_q <= '0;
    end else if (start) begin
      iso_q <= cfg_iso;
      odd_q <= cfg_odd_frame;
      mps_q <= cfg_mps;
    end
  end

  assign rx_push       = accept;
  assign rx_nak        = reject;
  assign irq_rx_level  = (level != '0);
  assign irq_xfer_done = done_q;
  assign ep_enabled    = en_q;
  assign rem_size      = size_left;
  assign rem_pkts      = pkts_left;
  assign fifo_level    = level;
  assign last_pid      = pid_q;

endmodule

// File: rtl/oep_xfer_checker.sv
// Temporal checks for out_ep_xfer_ctrl, attached by bind.
module oep_xfer_checker #(
  parameter int PKT_W = 4,
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_push,
  input logic             rx_nak,
  input logic             fifo_pop,
  input logic             ep_enabled,
  input logic             irq_xfer_done,
  input logic             iso_mode,
  input logic             odd_sel,
  input logic             frame_odd,
  input logic [PKT_W-1:0] rem_pkts,
  input logic [LVL_W-1:0] fifo_level,
  input logic [1:0]       last_pid
);

  p_no_push_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_enabled |-> !rx_push);

  p_nak_keeps_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_nak && ep_enabled) |=> $stable(rem_pkts));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  p_pkt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> (rem_pkts == $past(rem_pkts) - PKT_W'(1)));

  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && !rx_push && fifo_level != '0) |=>
      (fifo_level == $past(fifo_level) - LVL_W'(1)));

  p_done_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_xfer_done) |-> !ep_enabled);

  p_iso_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && iso_mode) |-> (frame_odd == odd_sel));

  p_pid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && !iso_mode) |=> $stable(last_pid));

endmodule

bind out_ep_xfer_ctrl oep_xfer_checker #(
  .PKT_W(PKT_W),
  .DEPTH(DEPTH),
  .LVL_W(LVL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .rx_push      (rx_push),
  .rx_nak       (rx_nak),
  .fifo_pop     (fifo_pop),
  .ep_enabled   (ep_enabled),
  .irq_xfer_done(irq_xfer_done),
  .iso_mode     (iso_q),
  .odd_sel      (odd_q),
  .frame_odd    (frame_odd),
  .rem_pkts     (rem_pkts),
  .fifo_level   (fifo_level),
  .last_pid     (last_pid)
);

// File: tb/out_ep_xfer_ctrl_test.sv
module out_ep_xfer_ctrl_test;

  localparam int SIZE_W = 10;
  localparam int PKT_W  = 4;
  localparam int BYTE_W = 7;
  localparam int DEPTH  = 4;
  localparam int LVL_W  = $clog2(DEPTH + 1);
  localparam int MPS    = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, cfg_enable, cfg_clear_nak, cfg_iso, cfg_odd_frame;
  logic [SIZE_W-1:0] cfg_size;
  logic [PKT_W-1:0]  cfg_pkts;
  logic [BYTE_W-1:0] cfg_mps;
  logic frame_odd, frame_sof, frame_eop;
  logic rx_valid;
  logic [BYTE_W-1:0] rx_bytes;
  logic [1:0] rx_pid;
  logic rx_push, rx_nak, fifo_pop, done_ack;
  logic irq_rx_level, irq_xfer_done, ep_enabled;
  logic [SIZE_W-1:0] rem_size;
  logic [PKT_W-1:0]  rem_pkts;
  logic [LVL_W-1:0]  fifo_level;
  logic [1:0]        last_pid;

  int checks = 0;
  int errors = 0;
  int exp_size, exp_pkts;

  always #4 clk = ~clk;

  out_ep_xfer_ctrl #(
    .SIZE_W(SIZE_W), .PKT_W(PKT_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_clear_nak(cfg_clear_nak),
    .cfg_iso(cfg_iso), .cfg_odd_frame(cfg_odd_frame),
    .cfg_size(cfg_size), .cfg_pkts(cfg_pkts), .cfg_mps(cfg_mps),
    .frame_odd(frame_odd), .frame_sof(frame_sof), .frame_eop(frame_eop),
    .rx_valid(rx_valid), .rx_bytes(rx_bytes), .rx_pid(rx_pid),
    .rx_push(rx_push), .rx_nak(rx_nak),
    .fifo_pop(fifo_pop), .done_ack(done_ack),
    .irq_rx_level(irq_rx_level), .irq_xfer_done(irq_xfer_done),
    .ep_enabled(ep_enabled), .rem_size(rem_size), .rem_pkts(rem_pkts),
    .fifo_level(fifo_level), .last_pid(last_pid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic arm(input int size, input int pkts, input bit iso,
                     input bit odd, input bit en, input bit cnak);
    cfg_size = SIZE_W'(size); cfg_pkts = PKT_W'(pkts); cfg_iso = iso;
    cfg_odd_frame = odd; cfg_enable = en; cfg_clear_nak = cnak;
    cfg_mps = BYTE_W'(MPS); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send(input int nb, input logic [1:0] pid, input bit acc,
                      input string tag);
    rx_valid = 1'b1; rx_bytes = BYTE_W'(nb); rx_pid = pid;
    #1;
    chk({tag, " push"}, int'(rx_push), int'(acc));
    chk({tag, " nak"}, int'(rx_nak), int'(!acc));
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop1();
    fifo_pop = 1'b1;
    @(negedge clk);
    fifo_pop = 1'b0;
  endtask

  task automatic ack();
    done_ack = 1'b1;
    @(negedge clk);
    done_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr = 0; cfg_enable = 0; cfg_clear_nak = 0; cfg_iso = 0; cfg_odd_frame = 0;
    cfg_size = '0; cfg_pkts = '0; cfg_mps = '0;
    frame_odd = 0; frame_sof = 0; frame_eop = 0;
    rx_valid = 0; rx_bytes = '0; rx_pid = 2'b00; fifo_pop = 0; done_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 enabled", int'(ep_enabled), 0);
    chk("R1 level", int'(fifo_level), 0);
    chk("R1 lvl irq", int'(irq_rx_level), 0);
    chk("R1 done irq", int'(irq_xfer_done), 0);
    chk("R1 last pid", int'(last_pid), 0);
    chk("R1 size", int'(rem_size), 0);
    chk("R1 pkts", int'(rem_pkts), 0);

    // R4 disabled endpoint refuses
    send(MPS, 2'b00, 1'b0, "R4 disabled");
    chk("R4 pkts after refuse", int'(rem_pkts), 0);

    // R2 incomplete writes ignored
    arm(100, 2, 0, 0, 1, 0);
    chk("R2 no clear-nak", int'(ep_enabled), 0);
    arm(100, 2, 0, 0, 0, 1);
    chk("R2 no enable", int'(ep_enabled), 0);
    chk("R2 size untouched", int'(rem_size), 0);

    // R3 R6 sweep: p packets, closing packet at position k (short when k<p)
    for (int p = 1; p <= 5; p++) begin
      for (int k = 1; k <= p; k++) begin
        arm(p * MPS, p, 0, 0, 1, 1);
        chk("R2 armed", int'(ep_enabled), 1);
        exp_size = p * MPS;
        exp_pkts = p;
        for (int i = 1; i <= k; i++) begin
          int nb;
          nb = (i == k && k < p) ? 17 : MPS;
          send(nb, 2'b00, 1'b1, "R3 sweep");
          exp_size -= nb;
          exp_pkts -= 1;
          if (i < k) pop1();
        end
        chk("R3 sweep size", int'(rem_size), exp_size);
        chk("R3 sweep pkts", int'(rem_pkts), exp_pkts);
        send(MPS, 2'b00, 1'b0, "R6 closed refuses");
        chk("R6 done before pop", int'(irq_xfer_done), 0);
        chk("R6 enabled before pop", int'(ep_enabled), 1);
        pop1();
        chk("R6 done after last pop", int'(irq_xfer_done), 1);
        chk("R6 disabled after last pop", int'(ep_enabled), 0);
        ack();
        chk("R6 done after ack", int'(irq_xfer_done), 0);
      end
    end

    // R4 R5 FIFO full
    arm(6 * MPS, 6, 0, 0, 1, 1);
    for (int i = 0; i < DEPTH; i++) send(MPS, 2'b00, 1'b1, "R3 fill");
    chk("R5 level full", int'(fifo_level), DEPTH);
    chk("R5 lvl irq", int'(irq_rx_level), 1);
    send(MPS, 2'b00, 1'b0, "R4 full refuses");
    chk("R4 pkts kept when full", int'(rem_pkts), 6 - DEPTH);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      pop1();
      chk("R5 level after pop", int'(fifo_level), i);
    end
    chk("R5 lvl irq empty", int'(irq_rx_level), 0);
    pop1();
    chk("R5 pop on empty", int'(fifo_level), 0);
    chk("R6 not done yet", int'(irq_xfer_done), 0);
    send(MPS, 2'b00, 1'b1, "R3 tail");
    send(MPS, 2'b00, 1'b1, "R3 tail");
    chk("R3 pkts zero", int'(rem_pkts), 0);
    pop1(); pop1();
    chk("R6 done full case", int'(irq_xfer_done), 1);

    // R3 size floor, R2 re-arm while enabled, zero-length short packet
    arm(50, 2, 0, 0, 1, 1);
    chk("R2 done cleared by arm", int'(irq_xfer_done), 0);
    arm(300, 5, 0, 0, 1, 1);
    chk("R2 re-arm ignored", int'(rem_size), 50);
    send(MPS, 2'b00, 1'b1, "R3 overrun");
    chk("R3 size floored", int'(rem_size), 0);
    chk("R3 pkts after overrun", int'(rem_pkts), 1);
    send(0, 2'b00, 1'b1, "R6 zero-length");
    pop1(); pop1();
    chk("R6 zero-length completes", int'(irq_xfer_done), 1);
    ack();

    // R7 R8 R9 isochronous, odd frame
    arm(2 * MPS, 2, 1, 1, 1, 1);
    chk("R10 armed at reset window", int'(ep_enabled), 1);
    frame_odd = 1'b0;
    send(MPS, 2'b00, 1'b0, "R7 wrong parity");
    chk("R7 pkts kept", int'(rem_pkts), 2);
    frame_odd = 1'b1;
    send(30, 2'b10, 1'b1, "R7 right parity");
    send(MPS, 2'b00, 1'b1, "R8 short does not close");
    chk("R8 pkts zero", int'(rem_pkts), 0);
    pop1();
    chk("R9 pid DATA1", int'(last_pid), 2);
    chk("R6 iso not done", int'(irq_xfer_done), 0);
    pop1();
    chk("R9 pid DATA0", int'(last_pid), 0);
    chk("R6 iso done", int'(irq_xfer_done), 1);

    // R10 window
    frame_sof = 1'b1; @(negedge clk); frame_sof = 1'b0;
    arm(2 * MPS, 2, 1, 0, 1, 1);
    chk("R10 iso arm outside window", int'(ep_enabled), 0);
    frame_eop = 1'b1; @(negedge clk); frame_eop = 1'b0;
    arm(2 * MPS, 2, 1, 0, 1, 1);
    chk("R10 iso arm inside window", int'(ep_enabled), 1);
    send(MPS, 2'b00, 1'b0, "R7 even selector odd frame");
    frame_odd = 1'b0;
    send(MPS, 2'b11, 1'b1, "R7 even frame");
    send(MPS, 2'b01, 1'b1, "R7 even frame");
    pop1();
    chk("R9 pid MDATA", int'(last_pid), 3);
    pop1();
    chk("R9 pid DATA2", int'(last_pid), 1);
    chk("R6 iso done 2", int'(irq_xfer_done), 1);

    // R9 non-isochronous pop leaves pid; R10 window irrelevant
    frame_sof = 1'b1; @(negedge clk); frame_sof = 1'b0;
    arm(MPS, 1, 0, 0, 1, 1);
    chk("R10 non-iso ignores window", int'(ep_enabled), 1);
    send(MPS, 2'b10, 1'b1, "R3 non-iso");
    pop1();
    chk("R9 non-iso pid held", int'(last_pid), 1);
    chk("R6 non-iso done", int'(irq_xfer_done), 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule